// File: doc/BRIEF.md
# Flag Offset Load Sequencer

This block holds the two threshold offsets that a FIFO's programmable flag logic compares against: the almost-empty offset and the almost-full offset. Software or a controller programs them through the FIFO's normal data ports rather than through dedicated address lines. While the offset-access strobe is high, a write request on the write clock stores the low data-input bits into the register the write-side sequencer currently selects. A read request on the read clock copies the register the read-side sequencer selects onto the data output.

Each sequencer steps from the almost-empty register to the almost-full register and then wraps back. The two sequencers step independently, so the registers can be read back in the order they were written. While the strobe is high, the block also withholds the FIFO's own push and pop qualifiers. Offset traffic therefore never moves the FIFO's data pointers. Both offsets drive the flag logic continuously. After reset each offset holds a default that depends on the FIFO depth.

Top module: `ofs_load_seq`

## Requirements
- R1: A synchronous reset (rst high at a write-clock edge) loads both offsets with the default: 31 when DEPTH is 256 or less, 63 when DEPTH is 512 or less, and 127 otherwise. A reset at a read-clock edge clears rd_data to zero. Reset returns both sequencers to the almost-empty register.
- R2: With ofs_mode high and wr_req high at a write-clock edge, bits [OFS_W-1:0] of wr_data go into the selected offset. The higher bits of wr_data are ignored.
- R3: Each write moves the write-side selection from the almost-empty register to the almost-full register, then back again. The first write after reset targets the almost-empty offset.
- R4: With ofs_mode high and rd_req high at a read-clock edge, rd_data takes the selected offset after that edge. The offset sits in bits [OFS_W-1:0] and the remaining bits are zero.
- R5: The read-side selection follows the same order as the write side (almost-empty, then almost-full, then wrap). It advances only on reads.
- R6: A write-clock edge without a qualified offset write leaves both offsets unchanged. A read-clock edge without a qualified readback leaves rd_data unchanged.
- R7: fifo_wr_ok equals wr_req and fifo_rd_ok equals rd_req while ofs_mode is low. Both are low while ofs_mode is high.
- R8: Dropping and raising ofs_mode does not move either selection; only a reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| ofs_mode | input | 1 | Offset-access strobe; high routes accesses to the offset registers |
| wr_req | input | 1 | Write request (active high) |
| wr_data | input | DATA_W | Write data bus |
| rd_req | input | 1 | Read request (active high) |
| rd_data | output | DATA_W | Registered readback of the selected offset |
| ae_offset | output | OFS_W | Almost-empty offset to flag logic |
| af_offset | output | OFS_W | Almost-full offset to flag logic |
| fifo_wr_ok | output | 1 | Push qualifier for the FIFO write pointer |
| fifo_rd_ok | output | 1 | Pop qualifier for the FIFO read pointer |

## Verification
The assertions check four things on every cycle:
- both offsets and the readback register hold still whenever no qualified access arrives;
- a qualified write leaves its data's low bits in one of the two offsets;
- the upper readback bits stay zero;
- the push and pop qualifiers are suppressed during offset access.

Only the bench's scenarios can show the stepping order, which needs a history of several accesses. These scenarios cover the almost-empty-first order, the wrap, the independence of the read and write sequencers, selection kept across strobe toggles, and the depth-dependent reset defaults.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  localparam int NUM_OFS = 2;

  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } ofs_sel_e;

  function automatic int default_offset(input int depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

  function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
    return (cur == SEL_AE) ? SEL_AF : SEL_AE;
  endfunction

endpackage

// File: rtl/ofs_wr_bank.sv
module ofs_wr_bank
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 18,
  parameter int DEF_OFS = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ofs_out [NUM_OFS]
);

  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

  ofs_sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= SEL_AE;
    else if (wr_hit) sel_q <= next_sel(sel_q);
  end

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_reg
    logic [OFS_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)
        val_q <= DEF_VAL;
      else if (wr_hit && (int'(sel_q) == g))
        val_q <= wr_data[OFS_W-1:0];
    end
    assign ofs_out[g] = val_q;
  end

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
  import ofs_seq_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [OFS_W-1:0]  ofs_in [NUM_OFS],
  output logic [DATA_W-1:0] rd_data
);

  ofs_sel_e          sel_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_AE;
      data_q <= '0;
    end else if (rd_hit) begin
      sel_q  <= next_sel(sel_q);
      data_q <= DATA_W'(ofs_in[sel_q]);
    end
  end

  assign rd_data = data_q;

endmodule

// File: rtl/ofs_fifo_gate.sv
module ofs_fifo_gate (
  input  logic ofs_mode,
  input  logic wr_req,
  input  logic rd_req,
  output logic fifo_wr_ok,
  output logic fifo_rd_ok,
  output logic wr_hit,
  output logic rd_hit
);

  always_comb begin
    fifo_wr_ok = wr_req & ~ofs_mode;
    fifo_rd_ok = rd_req & ~ofs_mode;
    wr_hit     = wr_req & ofs_mode;
    rd_hit     = rd_req & ofs_mode;
  end

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_seq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int OFS_W  = 12,
  parameter int DATA_W = 18
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              ofs_mode,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  ae_offset,
  output logic [OFS_W-1:0]  af_offset,
  output logic              fifo_wr_ok,
  output logic              fifo_rd_ok
);

  localparam int DEF_OFS = default_offset(DEPTH);

  logic             wr_hit;
  logic             rd_hit;
  logic [OFS_W-1:0] ofs_bank [NUM_OFS];

  ofs_fifo_gate u_gate (
    .ofs_mode  (ofs_mode),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .fifo_wr_ok(fifo_wr_ok),
    .fifo_rd_ok(fifo_rd_ok),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  ofs_wr_bank #(
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W),
    .DEF_OFS(DEF_OFS)
  ) u_wr (
    .clk    (wr_clk),
    .rst    (rst),
    .wr_hit (wr_hit),
    .wr_data(wr_data),
    .ofs_out(ofs_bank)
  );

  ofs_rd_port #(
    .OFS_W (OFS_W),
    .DATA_W(DATA_W)
  ) u_rd (
    .clk    (rd_clk),
    .rst    (rst),
    .rd_hit (rd_hit),
    .ofs_in (ofs_bank),
    .rd_data(rd_data)
  );

  assign ae_offset = ofs_bank[SEL_AE];
  assign af_offset = ofs_bank[SEL_AF];

endmodule

// File: rtl/ofs_load_seq_chk.sv
module ofs_load_seq_chk #(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 18,
  parameter int DEF_OFS = 31
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              ofs_mode,
  input logic              wr_req,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFS_W-1:0]  ae_offset,
  input logic [OFS_W-1:0]  af_offset,
  input logic              fifo_wr_ok,
  input logic              fifo_rd_ok
);

  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

  AST_RESET_DEFAULTS: assert property (@(posedge wr_clk)
    rst |=> (ae_offset == DEF_VAL) && (af_offset == DEF_VAL)); // R1

  AST_WRITE_LANDS: assert property (@(posedge wr_clk) disable iff (rst)
    (ofs_mode && wr_req) |=> (ae_offset == $past(wr_data[OFS_W-1:0]))
                          || (af_offset == $past(wr_data[OFS_W-1:0]))); // R2

  AST_OFS_HOLD: assert property (@(posedge wr_clk) disable iff (rst)
    !(ofs_mode && wr_req) |=> $stable(ae_offset) && $stable(af_offset)); // R6

  AST_RD_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    !(ofs_mode && rd_req) |=> $stable(rd_data)); // R6

  if (DATA_W > OFS_W) begin : g_upper
    AST_RD_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (rst)
      rd_data[DATA_W-1:OFS_W] == '0); // R4
  end

  AST_PUSH_BLOCKED: assert property (@(posedge wr_clk) disable iff (rst)
    ofs_mode |-> !fifo_wr_ok); // R7

  AST_POP_BLOCKED: assert property (@(posedge rd_clk) disable iff (rst)
    ofs_mode |-> !fifo_rd_ok); // R7

  AST_PUSH_PASS: assert property (@(posedge wr_clk) disable iff (rst)
    !ofs_mode |-> (fifo_wr_ok == wr_req)); // R7

endmodule

bind ofs_load_seq ofs_load_seq_chk #(
  .OFS_W  (OFS_W),
  .DATA_W (DATA_W),
  .DEF_OFS(DEF_OFS)
) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst       (rst),
  .ofs_mode  (ofs_mode),
  .wr_req    (wr_req),
  .wr_data   (wr_data),
  .rd_req    (rd_req),
  .rd_data   (rd_data),
  .ae_offset (ae_offset),
  .af_offset (af_offset),
  .fifo_wr_ok(fifo_wr_ok),
  .fifo_rd_ok(fifo_rd_ok)
);

// File: tb/sim_ofs_load_seq.sv
`timescale 1ns/1ps
module sim_ofs_load_seq;

  localparam int DW = 18;
  localparam int OW = 12;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          rst = 1'b1;
  logic          ofs_mode = 1'b0;
  logic          wr_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_req = 1'b0;
  logic [DW-1:0] rd_data, rd_data1;
  logic [OW-1:0] ae_offset, af_offset, ae1, af1;
  logic          fifo_wr_ok, fifo_rd_ok, fwo1, fro1;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.0;
    forever #2.5 rd_clk = ~rd_clk;
  end

  ofs_load_seq #(.DEPTH(256)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .ofs_mode(ofs_mode),
    .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .ae_offset(ae_offset), .af_offset(af_offset),
    .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok)
  );

  ofs_load_seq #(.DEPTH(512)) u1 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .ofs_mode(1'b0),
    .wr_req(1'b0), .wr_data('0), .rd_req(1'b0), .rd_data(rd_data1),
    .ae_offset(ae1), .af_offset(af1),
    .fifo_wr_ok(fwo1), .fifo_rd_ok(fro1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ofs_write(input logic [DW-1:0] d);
    @(negedge wr_clk);
    ofs_mode = 1'b1; wr_req = 1'b1; wr_data = d;
    @(negedge wr_clk);
    wr_req = 1'b0;
  endtask

  task automatic ofs_read();
    @(negedge wr_clk);
    ofs_mode = 1'b1; rd_req = 1'b1;
    @(negedge wr_clk);
    rd_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst = 1'b1;
    repeat (3) @(negedge wr_clk);
    rst = 1'b0;
    @(negedge wr_clk);
  endtask

  // kind: 0 = write then check ae, 1 = write then check af, 2 = read then check rd_data
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {2'd0, 18'h3F00A, 12'h00A},  // R2 upper bits dropped, first write to AE (R3)
    {2'd1, 18'h00FFF, 12'hFFF},  // R3 second write to AF
    {2'd0, 18'h00123, 12'h123},  // R3 wrap to AE
    {2'd2, 18'h00000, 12'h123},  // R4 R5 first read AE
    {2'd2, 18'h00000, 12'hFFF},  // R5 then AF
    {2'd2, 18'h00000, 12'h123},  // R5 wrap
    {2'd1, 18'h00456, 12'h456},  // R3 write side independent of reads
    {2'd2, 18'h00000, 12'h456}   // R5 read side independent of writes
  };

  initial begin : watchdog
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [11:0] ae_s, af_s;
    logic [DW-1:0] rd_s;
    do_reset();
    check("R1 ae default 256", 32'(ae_offset), 32'd31);
    check("R1 af default 256", 32'(af_offset), 32'd31);
    check("R1 ae default 512", 32'(ae1), 32'd63);
    check("R1 af default 512", 32'(af1), 32'd63);
    check("R1 rd_data cleared", 32'(rd_data), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [17:0] d;
      logic [11:0] e;
      {k, d, e} = VEC[i];
      if (k == 2'd2) begin
        ofs_read();
        check("R4 R5 readback", 32'(rd_data), 32'(e));
      end else begin
        ofs_write(d);
        if (k == 2'd0) check("R2 R3 ae written", 32'(ae_offset), 32'(e));
        else           check("R2 R3 af written", 32'(af_offset), 32'(e));
      end
    end

    // R7 qualifiers
    @(negedge wr_clk);
    ofs_mode = 1'b1; wr_req = 1'b1; rd_req = 1'b1; wr_data = 18'h00777;
    #0.1;
    check("R7 push blocked", 32'(fifo_wr_ok), 32'd0);
    check("R7 pop blocked", 32'(fifo_rd_ok), 32'd0);
    @(negedge wr_clk);
    wr_req = 1'b0; rd_req = 1'b0;
    // this pair wrote AE (0x777) and read AE (old 0x123 is overwritten same edge? read side sees value at its edge)
    ofs_mode = 1'b0;
    ae_s = ae_offset; af_s = af_offset; rd_s = rd_data;
    check("R2 ae after combined access", 32'(ae_s), 32'h777);

    // R6 / R7: requests with mode low
    @(negedge wr_clk);
    wr_req = 1'b1; rd_req = 1'b1; wr_data = 18'h00ABC;
    #0.1;
    check("R7 push passes", 32'(fifo_wr_ok), 32'd1);
    check("R7 pop passes", 32'(fifo_rd_ok), 32'd1);
    @(negedge wr_clk);
    wr_req = 1'b0; rd_req = 1'b0;
    @(negedge wr_clk);
    check("R6 ae held", 32'(ae_offset), 32'(ae_s));
    check("R6 af held", 32'(af_offset), 32'(af_s));
    check("R6 rd_data held", 32'(rd_data), 32'(rd_s));

    // R8 selection survives mode toggles: sequencers now point at AF
    ofs_write(18'h00055);
    @(negedge wr_clk); ofs_mode = 1'b0;
    @(negedge wr_clk);
    check("R8 write went to af", 32'(af_offset), 32'h055);
    ofs_read();
    check("R8 read from af", 32'(rd_data), 32'h055);

    // R1 reset mid-sequence returns selection to AE
    ofs_write(18'h00011);   // AE, selection -> AF
    ofs_read();             // AE, selection -> AF
    do_reset();
    check("R1 ae re-defaulted", 32'(ae_offset), 32'd31);
    check("R1 rd_data re-cleared", 32'(rd_data), 32'd0);
    ofs_write(18'h00099);
    check("R1 R3 first write after reset to ae", 32'(ae_offset), 32'h099);
    check("R1 af untouched", 32'(af_offset), 32'd31);
    ofs_read();
    check("R1 R5 first read after reset from ae", 32'(rd_data), 32'h099);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule